// File: doc/BRIEF.md
# Six-Master Shared Port Arbiter

This block decides which of six bus masters may drive a single shared slave port. Each master raises a request line. The arbiter answers with a registered grant vector that has at most one bit set. The master that holds the grant reports its own traffic through two signals: a transfer-valid strobe for each beat and a last flag on the final beat of a burst. Other logic handles address decoding, the data path and the rest of the bus handshake.

Configuration inputs come from static registers elsewhere. They select the ordering policy: lowest index wins, or a rotating order. They also select what the grant does on cycles with no request: release the port, leave it with the most recent owner, or hand it to one chosen master. A slot limit caps how many transfers an owner may make while others wait. The cap also applies to bursts that never signal a last beat.

Top module: `shared_port_arbiter`

## Requirements
- R1: `gnt_o` never has more than one bit set. On the first sample after synchronous reset, the grant is all zeros, the rotation start is master 0 and the remembered owner is master 0.
- R2: With `cfg_rr_i` = 0, the requesting candidate with the lowest index wins each arbitration.
- R3: With `cfg_rr_i` = 1, the search starts at the master after the last one granted for a request, wrapping from master 5 to master 0.
- R4: An owner that keeps its request keeps the grant until a cycle with both `xfer_valid_i` and `xfer_last_i` high. A new decision is seen on `gnt_o` one clock after the inputs that caused it are sampled.
- R5: Parking code 0 (and the unused code 3) gives an all-zero grant on any arbitration that finds no request.
- R6: Parking code 1 gives the grant to the master most recently granted for a request (master 0 if none yet) when no request is pending.
- R7: Parking code 2 gives the grant to master `cfg_park_idx_i` when no request is pending. An index of 6 or 7 gives an all-zero grant.
- R8: Each arbitration loads a slot counter with `cfg_slot_limit_i`. Each later transfer cycle of the same owner counts it down to a floor of zero. On a transfer cycle where the counter is at most 1, the limit is non-zero and another master is requesting, the grant moves to one of the other requesters, even with no last beat.
- R9: A slot limit of 0 never takes the grant from an owner that keeps requesting.
- R10: A parked master that starts requesting keeps its grant with no idle cycle.
- R11: When the grant is zero or the owner has dropped its request, any pending request is granted on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 6 | Request line from each master |
| xfer_valid_i | input | 1 | Current owner performs a transfer this cycle |
| xfer_last_i | input | 1 | Current transfer is the last beat of its burst |
| cfg_rr_i | input | 1 | 1 selects rotating order, 0 selects lowest index first |
| cfg_park_i | input | 2 | Idle parking: 0 release, 1 most recent owner, 2 fixed master, 3 release |
| cfg_park_idx_i | input | 3 | Master that receives the idle grant under parking code 2 |
| cfg_slot_limit_i | input | 8 | Transfer budget per ownership, 0 disables preemption |
| gnt_o | output | 6 | One-hot grant, all zeros when nobody owns the port |

## Verification
A stale rotation pointer or remembered owner stays hidden until the next arbitration that has several requests or none. On that clock it shows up as a grant to the wrong master. The bench therefore keeps all six request lines busy and often lets the queue drain to empty. A slot counter that is off by one moves the grant one transfer too early or too late, so preemption runs are checked every cycle. A hold condition that is too loose shows up within one clock as a grant that changes while the owner is still mid-burst.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int unsigned ARB_N  = 6;
    localparam int unsigned ARB_SW = 8;

    typedef enum logic [1:0] {
        PARK_OFF   = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2,
        PARK_RSVD  = 2'd3
    } park_mode_e;

    // index following i in a ring of n masters
    function automatic int unsigned arb_wrap(input int unsigned i, input int unsigned n);
        return (i + 1 >= n) ? 0 : i + 1;
    endfunction

endpackage

// File: rtl/arb_select.sv
module arb_select #(
    parameter int unsigned N  = arb_pkg::ARB_N,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    input  logic          rr_mode,
    input  logic [IW-1:0] rr_ptr,
    output logic          hit,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] rr_pos [N];

    // position g of the rotating search order, starting at rr_ptr
    for (genvar g = 0; g < N; g++) begin : g_rot
        logic [IW:0] sum;
        assign sum       = {1'b0, rr_ptr} + (IW+1)'(g);
        assign rr_pos[g] = (sum >= (IW+1)'(N)) ? IW'(sum - (IW+1)'(N)) : IW'(sum);
    end

    always_comb begin
        logic [IW-1:0] pos;
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            pos = rr_mode ? rr_pos[i] : IW'(i);
            if (!hit && cand[pos]) begin
                hit = 1'b1;
                idx = pos;
            end
        end
    end
endmodule

// File: rtl/arb_park.sv
module arb_park #(
    parameter int unsigned N  = arb_pkg::ARB_N,
    parameter int unsigned IW = $clog2(N)
) (
    input  arb_pkg::park_mode_e mode,
    input  logic [IW-1:0]       last_idx,
    input  logic [IW-1:0]       fixed_idx,
    output logic                vld,
    output logic [IW-1:0]       idx
);
    always_comb begin
        vld = 1'b0;
        idx = '0;
        unique case (mode)
            arb_pkg::PARK_LAST: begin
                vld = 1'b1;
                idx = last_idx;
            end
            arb_pkg::PARK_FIXED: begin
                vld = (32'(fixed_idx) < N);
                idx = fixed_idx;
            end
            default: begin
                vld = 1'b0;
                idx = '0;
            end
        endcase
    end
endmodule

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
    parameter int unsigned SW = arb_pkg::ARB_SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          xfer,
    input  logic [SW-1:0] limit,
    output logic          spent
);
    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= limit;
        end else if (xfer && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // budget used up once the transfer in flight is the last allowed one
    assign spent = (limit != '0) && (cnt_q <= SW'(1));
endmodule

// File: rtl/shared_port_arbiter.sv
module shared_port_arbiter #(
    parameter int unsigned N_MASTERS = arb_pkg::ARB_N,
    parameter int unsigned SLOT_W    = arb_pkg::ARB_SW,
    localparam int unsigned IDX_W    = $clog2(N_MASTERS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 xfer_valid_i,
    input  logic                 xfer_last_i,
    input  logic                 cfg_rr_i,
    input  logic [1:0]           cfg_park_i,
    input  logic [IDX_W-1:0]     cfg_park_idx_i,
    input  logic [SLOT_W-1:0]    cfg_slot_limit_i,
    output logic [N_MASTERS-1:0] gnt_o
);
    import arb_pkg::*;

    logic [N_MASTERS-1:0] gnt_q, gnt_d;
    logic [IDX_W-1:0]     ptr_q, ptr_d;
    logic [IDX_W-1:0]     last_q, last_d;

    logic                 owner_req, burst_done, preempt, hold, spent;
    logic [N_MASTERS-1:0] others, cand;
    logic                 sel_hit, park_vld;
    logic [IDX_W-1:0]     sel_idx, park_idx;

    assign owner_req  = |(req_i & gnt_q);
    assign others     = req_i & ~gnt_q;
    assign burst_done = xfer_valid_i && xfer_last_i;
    assign preempt    = (|gnt_q) && xfer_valid_i && spent && (|others);
    assign hold       = owner_req && !burst_done && !preempt;
    assign cand       = preempt ? others : req_i;

    arb_select #(.N(N_MASTERS), .IW(IDX_W)) u_select (
        .cand    (cand),
        .rr_mode (cfg_rr_i),
        .rr_ptr  (ptr_q),
        .hit     (sel_hit),
        .idx     (sel_idx)
    );

    arb_park #(.N(N_MASTERS), .IW(IDX_W)) u_park (
        .mode      (park_mode_e'(cfg_park_i)),
        .last_idx  (last_q),
        .fixed_idx (cfg_park_idx_i),
        .vld       (park_vld),
        .idx       (park_idx)
    );

    arb_slot_timer #(.SW(SLOT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load  (!hold),
        .xfer  (xfer_valid_i),
        .limit (cfg_slot_limit_i),
        .spent (spent)
    );

    always_comb begin
        gnt_d  = gnt_q;
        ptr_d  = ptr_q;
        last_d = last_q;
        if (!hold) begin
            if (sel_hit) begin
                gnt_d  = N_MASTERS'(1) << sel_idx;
                ptr_d  = IDX_W'(arb_wrap(32'(sel_idx), N_MASTERS));
                last_d = sel_idx;
            end else if (park_vld) begin
                gnt_d  = N_MASTERS'(1) << park_idx;
            end else begin
                gnt_d  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q  <= '0;
            ptr_q  <= '0;
            last_q <= '0;
        end else begin
            gnt_q  <= gnt_d;
            ptr_q  <= ptr_d;
            last_q <= last_d;
        end
    end

    assign gnt_o = gnt_q;
endmodule

// File: rtl/shared_port_arbiter_chk.sv
module shared_port_arbiter_chk #(
    parameter int unsigned N  = 6,
    parameter int unsigned IW = 3,
    parameter int unsigned SW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  req_i,
    input logic          xfer_valid_i,
    input logic          xfer_last_i,
    input logic          cfg_rr_i,
    input logic [1:0]    cfg_park_i,
    input logic [IW-1:0] cfg_park_idx_i,
    input logic [SW-1:0] cfg_slot_limit_i,
    input logic [N-1:0]  gnt_o
);
    a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    a_r2_lowest_first: assert property (@(posedge clk) disable iff (rst)
        (gnt_o == '0 && !cfg_rr_i && req_i != '0)
        |=> gnt_o == $past(req_i & (~req_i + N'(1))));

    a_r4_hold_no_xfer: assert property (@(posedge clk) disable iff (rst)
        ((|(req_i & gnt_o)) && !xfer_valid_i) |=> $stable(gnt_o));

    a_r5_release_idle: assert property (@(posedge clk) disable iff (rst)
        (cfg_park_i == 2'd0 && req_i == '0) |=> gnt_o == '0);

    a_r7_fixed_park: assert property (@(posedge clk) disable iff (rst)
        (cfg_park_i == 2'd2 && 32'(cfg_park_idx_i) < N && req_i == '0)
        |=> gnt_o == (N'(1) << $past(cfg_park_idx_i)));

    a_r9_no_limit_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_slot_limit_i == '0 && (|(req_i & gnt_o)) && !(xfer_valid_i && xfer_last_i))
        |=> $stable(gnt_o));

    a_r11_idle_grant: assert property (@(posedge clk) disable iff (rst)
        (gnt_o == '0 && req_i != '0) |=> (gnt_o & $past(req_i)) != '0);
endmodule

bind shared_port_arbiter shared_port_arbiter_chk #(
    .N(N_MASTERS), .IW(IDX_W), .SW(SLOT_W)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .req_i            (req_i),
    .xfer_valid_i     (xfer_valid_i),
    .xfer_last_i      (xfer_last_i),
    .cfg_rr_i         (cfg_rr_i),
    .cfg_park_i       (cfg_park_i),
    .cfg_park_idx_i   (cfg_park_idx_i),
    .cfg_slot_limit_i (cfg_slot_limit_i),
    .gnt_o            (gnt_o)
);

// File: tb/shared_port_arbiter_tb.sv
module shared_port_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] req = '0;
    logic       xv = 1'b0, xl = 1'b0;
    logic       rr = 1'b0;
    logic [1:0] park = 2'd0;
    logic [2:0] pidx = 3'd0;
    logic [7:0] lim = 8'd0;
    logic [5:0] gnt;

    int checks = 0;
    int errors = 0;

    // reference state
    bit m_vld;
    int m_own, m_ptr, m_last, m_cnt;

    always #10 clk = ~clk;

    shared_port_arbiter u_dut (
        .clk(clk), .rst(rst), .req_i(req), .xfer_valid_i(xv), .xfer_last_i(xl),
        .cfg_rr_i(rr), .cfg_park_i(park), .cfg_park_idx_i(pidx),
        .cfg_slot_limit_i(lim), .gnt_o(gnt)
    );

    function automatic int pick(input logic [5:0] c);
        for (int k = 0; k < 6; k++) begin
            int i = rr ? (m_ptr + k) % 6 : k;
            if (c[i]) return i;
        end
        return -1;
    endfunction

    function automatic logic [5:0] exp_gnt();
        return m_vld ? 6'(1 << m_own) : 6'd0;
    endfunction

    task automatic model_update(input logic [5:0] r, input logic v, input logic l);
        logic [5:0] oth = r & ~exp_gnt();
        bit own_req = m_vld && r[m_own];
        bit pre = m_vld && v && (lim != 0) && (m_cnt <= 1) && (oth != 0);
        if (own_req && !(v && l) && !pre) begin
            if (v && m_cnt > 0) m_cnt--;
        end else begin
            int w = pick(pre ? oth : r);
            if (w >= 0) begin
                m_vld = 1; m_own = w; m_ptr = (w + 1) % 6; m_last = w;
            end else if (park == 2'd1) begin
                m_vld = 1; m_own = m_last;
            end else if (park == 2'd2 && pidx < 6) begin
                m_vld = 1; m_own = int'(pidx);
            end else begin
                m_vld = 0;
            end
            m_cnt = int'(lim);
        end
    endtask

    task automatic step(input logic [5:0] r, input logic v, input logic l, input string tag);
        req = r; xv = v; xl = l;
        model_update(r, v, l);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (gnt !== exp_gnt()) begin
            errors++;
            $display("FAIL %s gnt=%b expected=%b", tag, gnt, exp_gnt());
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_vld = 0; m_own = 0; m_ptr = 0; m_last = 0; m_cnt = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (gnt !== 6'd0) begin
            errors++;
            $display("FAIL R1 reset gnt=%b expected=%b", gnt, 6'd0);
        end

        // R2 lowest index first
        rr = 0; park = 2'd0; lim = 8'd0;
        step(6'b101100, 0, 0, "R2");
        step(6'b101101, 1, 1, "R2");
        // R4 owner holds through a long burst
        for (int i = 0; i < 5; i++) step(6'b111111, 1, 0, "R4");
        step(6'b111111, 0, 0, "R4");
        // R5 release when idle, R11 immediate grant
        step(6'b000000, 0, 0, "R5");
        step(6'b010000, 0, 0, "R11");
        // R3 rotation with every master asking
        rr = 1;
        for (int i = 0; i < 9; i++) step(6'b111111, 1, 1, "R3");
        step(6'b100001, 1, 1, "R3");
        step(6'b100001, 1, 1, "R3");
        // R6 park on last owner
        park = 2'd1;
        step(6'b000000, 0, 0, "R6");
        step(6'b000000, 0, 0, "R6");
        // R7 fixed park, R10 parked master keeps grant
        park = 2'd2; pidx = 3'd3;
        step(6'b000000, 0, 0, "R7");
        step(6'b001000, 0, 0, "R10");
        step(6'b001001, 1, 0, "R10");
        step(6'b001000, 1, 1, "R10");
        pidx = 3'd6;
        step(6'b000000, 0, 0, "R7");
        step(6'b000000, 0, 0, "R7");
        // R8 slot limit on an open-ended burst
        park = 2'd0; lim = 8'd3;
        step(6'b000011, 0, 0, "R8");
        for (int i = 0; i < 8; i++) step(6'b000011, 1, 0, "R8");
        rr = 0;
        for (int i = 0; i < 8; i++) step(6'b000111, 1, 0, "R8");
        // R9 limit zero never preempts
        lim = 8'd0;
        for (int i = 0; i < 10; i++) step(6'b000011, 1, 0, "R9");

        // random mix
        for (int blk = 0; blk < 20; blk++) begin
            rr   = 1'($urandom % 2);
            park = 2'($urandom % 4);
            pidx = 3'($urandom % 8);
            lim  = 8'($urandom % 6);
            for (int c = 0; c < 150; c++) begin
                logic [5:0] r = ($urandom % 5 == 0) ? 6'd0 : 6'($urandom);
                step(r, ($urandom % 10) < 7, ($urandom % 4) == 0, "R2 R3 R8 random");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule